// File: doc/BRIEF.md
# Debounced Press-Release Event Counter

This block watches a single mechanical pushbutton wired active low: the raw line reads 1 while the button is up and 0 while it is held down. It recognises one activation for each full cycle of pressing and then letting go. Holding the button down produces nothing more. After each recognised edge it ignores the line for a fixed settle time, so contact bounce cannot create extra activations. The activation becomes visible only once the settle time after the release has run out.

Each activation adds one to a wrapping counter and fires a one-clock strobe. It also drives an LED in one of two ways, chosen by a mode input that is sampled at the moment of activation. In toggle mode the LED changes state. In blink mode the LED pulses twice: on, off, on, off, each phase lasting a fixed number of milliseconds. While that sequence runs, the button is not watched.

All delays are whole multiples of a 1 ms tick. The tick is made from a clock-cycle divider whose length is a parameter, so a bench can shrink time. Both delay lengths are also parameters, with defaults of 30 ms for settling and 200 ms for a blink phase.

Top module: `press_release_counter`

## Requirements
- R1: While reset is asserted, and right after it, pressCount is 0, ledOut is 0 and activationPulse is 0. The block then waits for a press.
- R2: The raw button line passes through a two-flop synchronizer that resets to the released level. A 0 on the line means pressed.
- R3: Each press followed by a release gives exactly one activation. Holding the button down for any length of time gives none.
- R4: Once a press is seen, the line is ignored for SETTLE_MS·CYCLES_PER_MS cycles. Bounce on the line during this window does not change the result.
- R5: Once a release is seen, the line is ignored for SETTLE_MS·CYCLES_PER_MS cycles. The activation takes effect on the clock edge that comes SETTLE_MS·CYCLES_PER_MS+2 edges after the first edge that samples the line released.
- R6: activationPulse is high for exactly one clock per activation, in the same cycle that pressCount first shows its new value.
- R7: pressCount rises by exactly one per activation and changes at no other time. From all ones it wraps to 0.
- R8: With blinkMode at 0 when an activation occurs, ledOut inverts at that activation.
- R9: With blinkMode at 1 when an activation occurs, ledOut goes high at the activation edge. It then follows four phases of BLINK_MS·CYCLES_PER_MS cycles each: high, low, high, low. It ends low, and the block then waits for a press.
- R10: Pressing or releasing the button while a blink sequence runs produces no activation and no count change.
- R11: blinkMode is sampled only at the activation edge. Changing it at any other time, including during a blink sequence, has no effect on the LED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| buttonN | input | 1 | Raw pushbutton line, 0 = pressed |
| blinkMode | input | 1 | 1 = double blink per activation, 0 = toggle |
| pressCount | output | COUNT_W | Activation count, wraps |
| ledOut | output | 1 | LED drive, 1 = on |
| activationPulse | output | 1 | One-clock strobe per activation |

## Verification
The hardest case to reach from the ports is the counter wrap. A 16-bit count needs 65536 full press-release cycles, each with two settle windows, which is far beyond a practical run. The bench therefore runs a second instance with a 4-bit count from the same button. Over about twenty activations it checks that narrow count against the wide count modulo 16, and that includes the wrap past all ones.

The bench also brings about button activity inside a running blink sequence, and a mode change in the middle of that sequence. It does this by timing the stimulus in cycles from the observed activation strobe. Bounce inside each settle window is driven the same way.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_PRESS,
    ST_SETTLE_PRESS,
    ST_WAIT_RELEASE,
    ST_SETTLE_RELEASE,
    ST_BLINK_ON_A,
    ST_BLINK_OFF_A,
    ST_BLINK_ON_B,
    ST_BLINK_OFF_B
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startDelay;  // restart ms timer
    logic longDelay;   // with startDelay: blink length, else settle length
    logic countUp;     // activation: bump count, fire strobe
    logic ledToggle;
    logic ledSet;
    logic ledClear;
  } dpStrobes_t;

endpackage

// File: rtl/prc_sync.sv
module prc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;   // idle level is "released"
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/prc_datapath.sv
module prc_datapath
  import prc_pkg::*;
#(
  parameter int CYCLES_PER_MS = 125000,
  parameter int SETTLE_MS     = 30,
  parameter int BLINK_MS      = 200,
  parameter int COUNT_W       = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  output logic               delayDone,
  output logic [COUNT_W-1:0] pressCount,
  output logic               ledOut,
  output logic               activationPulse
);
  localparam int DIV_W  = $clog2(CYCLES_PER_MS + 1);
  localparam int MS_MAX = (BLINK_MS > SETTLE_MS) ? BLINK_MS : SETTLE_MS;
  localparam int MS_W   = $clog2(MS_MAX + 1);
  localparam logic [DIV_W-1:0] DIV_LAST    = DIV_W'(CYCLES_PER_MS - 1);
  localparam logic [MS_W-1:0]  SETTLE_LAST = MS_W'(SETTLE_MS - 1);
  localparam logic [MS_W-1:0]  BLINK_LAST  = MS_W'(BLINK_MS - 1);
  localparam logic [MS_W-1:0]  MS_CAP      = MS_W'(MS_MAX);

  logic [DIV_W-1:0] divCnt;
  logic [MS_W-1:0]  msCnt;
  logic             longSel;
  logic             divLast;

  assign divLast = (divCnt == DIV_LAST);

  // ms timer: divider and ms counter both restart on startDelay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      msCnt   <= '0;
      longSel <= 1'b0;
    end else if (strobes.startDelay) begin
      divCnt  <= '0;
      msCnt   <= '0;
      longSel <= strobes.longDelay;
    end else if (divLast) begin
      divCnt <= '0;
      if (msCnt != MS_CAP) msCnt <= msCnt + MS_W'(1);
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign delayDone = divLast && (msCnt == (longSel ? BLINK_LAST : SETTLE_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pressCount      <= '0;
      activationPulse <= 1'b0;
      ledOut          <= 1'b0;
    end else begin
      activationPulse <= strobes.countUp;
      if (strobes.countUp) pressCount <= pressCount + COUNT_W'(1);
      if (strobes.ledSet)         ledOut <= 1'b1;
      else if (strobes.ledClear)  ledOut <= 1'b0;
      else if (strobes.ledToggle) ledOut <= ~ledOut;
    end
  end

  // R6: strobe never lasts two cycles
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    activationPulse |=> !activationPulse);
  // R7: count steps by one (mod 2^COUNT_W) with the strobe
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    activationPulse |-> pressCount == $past(pressCount) + COUNT_W'(1));
  // R7: count is quiet without an activation
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !activationPulse |-> $stable(pressCount));
endmodule

// File: rtl/prc_ctrl.sv
module prc_ctrl
  import prc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnSync,
  input  logic       blinkMode,
  input  logic       delayDone,
  output dpStrobes_t strobes
);
  ctrlState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT_PRESS;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_WAIT_PRESS: if (!btnSync) begin
        stateNext          = ST_SETTLE_PRESS;
        strobes.startDelay = 1'b1;
      end
      ST_SETTLE_PRESS: if (delayDone) stateNext = ST_WAIT_RELEASE;
      ST_WAIT_RELEASE: if (btnSync) begin
        stateNext          = ST_SETTLE_RELEASE;
        strobes.startDelay = 1'b1;
      end
      ST_SETTLE_RELEASE: if (delayDone) begin
        strobes.countUp = 1'b1;
        if (blinkMode) begin
          stateNext          = ST_BLINK_ON_A;
          strobes.startDelay = 1'b1;
          strobes.longDelay  = 1'b1;
          strobes.ledSet     = 1'b1;
        end else begin
          stateNext         = ST_WAIT_PRESS;
          strobes.ledToggle = 1'b1;
        end
      end
      ST_BLINK_ON_A: if (delayDone) begin
        stateNext          = ST_BLINK_OFF_A;
        strobes.startDelay = 1'b1;
        strobes.longDelay  = 1'b1;
        strobes.ledClear   = 1'b1;
      end
      ST_BLINK_OFF_A: if (delayDone) begin
        stateNext          = ST_BLINK_ON_B;
        strobes.startDelay = 1'b1;
        strobes.longDelay  = 1'b1;
        strobes.ledSet     = 1'b1;
      end
      ST_BLINK_ON_B: if (delayDone) begin
        stateNext          = ST_BLINK_OFF_B;
        strobes.startDelay = 1'b1;
        strobes.longDelay  = 1'b1;
        strobes.ledClear   = 1'b1;
      end
      ST_BLINK_OFF_B: if (delayDone) stateNext = ST_WAIT_PRESS;
      default: stateNext = ST_WAIT_PRESS;
    endcase
  end

  // R3: release can only be awaited after a settled press
  assert_release_after_press_R3: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_WAIT_RELEASE |->
      ($past(state) == ST_SETTLE_PRESS || $past(state) == ST_WAIT_RELEASE));
  // R9: blink sequence starts only from a completed release settle
  assert_blink_entry_R9: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_BLINK_ON_A |->
      ($past(state) == ST_SETTLE_RELEASE || $past(state) == ST_BLINK_ON_A));
endmodule

// File: rtl/press_release_counter.sv
module press_release_counter
  import prc_pkg::*;
#(
  parameter int CYCLES_PER_MS = 125000,
  parameter int SETTLE_MS     = 30,
  parameter int BLINK_MS      = 200,
  parameter int COUNT_W       = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               buttonN,
  input  logic               blinkMode,
  output logic [COUNT_W-1:0] pressCount,
  output logic               ledOut,
  output logic               activationPulse
);
  logic       btnSync;
  logic       delayDone;
  dpStrobes_t strobes;

  prc_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din(buttonN), .dout(btnSync)
  );

  prc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .btnSync(btnSync), .blinkMode(blinkMode),
    .delayDone(delayDone), .strobes(strobes)
  );

  prc_datapath #(
    .CYCLES_PER_MS(CYCLES_PER_MS), .SETTLE_MS(SETTLE_MS),
    .BLINK_MS(BLINK_MS), .COUNT_W(COUNT_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .delayDone(delayDone),
    .pressCount(pressCount), .ledOut(ledOut), .activationPulse(activationPulse)
  );
endmodule

// File: tb/tb_press_release_counter.sv
`timescale 1ns/1ps
module tb_press_release_counter;
  localparam int CPM = 2;
  localparam int SMS = 3;
  localparam int BMS = 4;
  localparam int SC  = SMS * CPM;
  localparam int BC  = BMS * CPM;
  localparam int EV  = 3 + SC;   // negedge index of activation after release

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic buttonN = 1'b1;
  logic blinkMode = 1'b0;
  logic [15:0] pressCount;
  logic [3:0]  narrowCount;
  logic ledOut, ledNarrow, activationPulse, pulseNarrow;

  int checks = 0;
  int errors = 0;
  int expCount = 0;
  logic expLed = 1'b0;

  always #4 clk = ~clk;

  press_release_counter #(.CYCLES_PER_MS(CPM), .SETTLE_MS(SMS), .BLINK_MS(BMS), .COUNT_W(16)) dut (
    .clk(clk), .rstN(rstN), .buttonN(buttonN), .blinkMode(blinkMode),
    .pressCount(pressCount), .ledOut(ledOut), .activationPulse(activationPulse));

  press_release_counter #(.CYCLES_PER_MS(CPM), .SETTLE_MS(SMS), .BLINK_MS(BMS), .COUNT_W(4)) dutNarrow (
    .clk(clk), .rstN(rstN), .buttonN(buttonN), .blinkMode(blinkMode),
    .pressCount(narrowCount), .ledOut(ledNarrow), .activationPulse(pulseNarrow));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // full press and release; returns at the negedge after the activation
  task automatic activate(input int hold, input bit bounce, input bit modeAtRelease);
    bit early = 0;
    int startCount = expCount;
    @(negedge clk); buttonN = 1'b0;
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk);
      if (bounce && i <= 4) buttonN = i[0] ? 1'b1 : 1'b0;  // R4 bounce, ends pressed
      if (activationPulse || pressCount != 16'(startCount)) early = 1;
    end
    check(!early, "R3", "activation while held", longint'(pressCount), startCount);
    buttonN = 1'b1;
    blinkMode = modeAtRelease;
    early = 0;
    for (int i = 1; i <= EV; i++) begin
      @(negedge clk);
      if (bounce && i <= 4) buttonN = i[0] ? 1'b0 : 1'b1;  // R5 bounce, ends released
      if (i < EV && activationPulse) early = 1;
    end
    check(!early, "R5", "strobe before release settle end", 1, 0);
    expCount++;
    check(activationPulse == 1'b1, "R5", "strobe at release settle end", activationPulse, 1);
    check(pressCount == 16'(expCount), "R7", "count", pressCount, expCount);
    check(narrowCount == 4'(expCount), "R7", "narrow count wrap", narrowCount, expCount % 16);
    if (modeAtRelease) expLed = 1'b1; else expLed = ~expLed;
    check(ledOut == expLed, modeAtRelease ? "R9" : "R8", "led at activation", ledOut, expLed);
    @(negedge clk);
    check(activationPulse == 1'b0, "R6", "strobe width", activationPulse, 0);
  endtask

  // continues from offset 1 after a blink-mode activation
  task automatic blinkCheck(input bit disturb);
    bit ledBad = 0;
    bit pulseSeen = 0;
    for (int k = 2; k <= 4 * BC + 2; k++) begin
      @(negedge clk);
      if (disturb && k == 3) buttonN = 1'b0;
      if (disturb && k == 5) blinkMode = 1'b0;          // R11 mid-sequence change
      if (disturb && k == SC + 7) buttonN = 1'b1;
      if (ledOut != ((k < BC) || (k >= 2 * BC && k < 3 * BC))) ledBad = 1;
      if (activationPulse) pulseSeen = 1;
    end
    check(!ledBad, "R9", "blink phase pattern", ledBad, 0);
    check(!pulseSeen, "R10", "strobe during blink", pulseSeen, 0);
    check(pressCount == 16'(expCount), "R10", "count after blink", pressCount, expCount);
    check(ledOut == 1'b0, "R9", "led off after blink", ledOut, 0);
    expLed = 1'b0;
  endtask

  initial begin
    int w = 0;
    while (w < 100000) begin @(posedge clk); w++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pressCount == 16'd0, "R1", "count in reset", pressCount, 0);
    check(ledOut == 1'b0, "R1", "led in reset", ledOut, 0);
    check(activationPulse == 1'b0, "R1", "strobe in reset", activationPulse, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(pressCount == 16'd0 && ledOut == 1'b0, "R1", "idle after reset", pressCount, 0);
    // R2 R3 R8: plain activation, toggle mode
    activate(SC + 4, 0, 0);
    // R3: long hold
    activate(200, 0, 0);
    // R4 R5: bounce on both edges
    activate(SC + 6, 1, 0);
    // R7: wrap of narrow instance
    for (int n = 0; n < 16; n++) activate(SC + 3 + (n % 3), n[0], 0);
    // R9 R11: mode raised only at release
    activate(SC + 4, 0, 1);
    blinkCheck(0);
    // R10 R11: disturbance and mode change during blink
    activate(SC + 4, 0, 1);
    blinkCheck(1);
    // R10: next press counts exactly once, R8 toggle from off
    activate(SC + 4, 0, 0);
    check(ledOut == 1'b1, "R8", "toggle after blink", ledOut, 1);
    repeat (20) @(negedge clk);
    check(pressCount == 16'(expCount), "R3", "no stray activation", pressCount, expCount);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule